// File: doc/BRIEF.md
# Linked-Row Subentry Store for a Miss Handler

This block keeps the per-miss records of a non-blocking miss handler. Each record, called a subentry, is a requester ID plus the word offset that requester wants inside a cache line. Subentries are packed into fixed-size rows in a shared row store. Every tracked line owns a singly linked chain of rows. A line begins with one row. When its last row fills up, another row is taken from a pool of free rows and linked to the end of the chain.

A one-entry tail cache remembers the last row of the most recently touched line. When the cache holds that line, an append needs no walk through the chain. When line data comes back from memory, the block walks the line's chain from its head. It emits one response per subentry, carrying the ID and the word picked by that subentry's offset, and it returns every drained row to the pool.

The line index, a small handle given by the surrounding miss handler, selects the chain. Looking up line addresses happens outside this block.

Top module: `sb_row_buffer`

## Requirements
- R1: After reset no response is emitted, and the free-row pool holds every row: exactly SB_ROWS rows (8 by default) can be taken before any is returned.
- R2: A request with `ins_new`=1 starts a chain for `ins_line` with one fresh row. It is accepted in the same cycle it is presented (`ins_ready`=1 while `ins_valid`=1) whenever a row is free. `ins_ready` is never high without `ins_valid`.
- R3: An append to a line whose tail row is held by the tail cache and has a free slot is accepted in the cycle it is presented, so back-to-back appends need no idle cycle.
- R4: An append whose tail row already holds SB_SLOTS (2) subentries stalls for exactly one cycle while a new row is linked. It is then accepted.
- R5: An append to a line that is not the one in the tail cache stalls for K+1 cycles, where K is the number of rows in that line's chain. One more cycle is added if the tail row is full.
- R6: After a response for a line is accepted, one output per stored subentry appears on consecutive cycles, starting in the cycle after the handshake, in insertion order. Each output carries its ID and the word `rsp_data[off*SB_WORD_W +: SB_WORD_W]`.
- R7: All rows of a drained line return to the pool and can be handed out again. A line index can start a new chain after its drain.
- R8: When the pool is empty and a request needs a row, `ins_ready` stays low until a drain frees rows.
- R9: While a response is draining, `ins_ready` is low and `rsp_ready` is low. If a response and a request are presented in the same idle cycle, the response is taken first and the request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Subentry insertion request |
| ins_ready | output | 1 | Insertion accepted this cycle |
| ins_new | input | 1 | 1: first miss of the line (start chain), 0: append |
| ins_line | input | 2 | Line handle |
| ins_id | input | 4 | Requester ID |
| ins_off | input | 2 | Word offset inside the line |
| rsp_valid | input | 1 | Line data returned from memory |
| rsp_ready | output | 1 | Line data accepted this cycle |
| rsp_line | input | 2 | Line handle of the returning data |
| rsp_data | input | 32 | Whole line, word k at bits [8k+7:8k] |
| out_valid | output | 1 | A response to one requester |
| out_id | output | 4 | Requester ID of the response |
| out_word | output | 8 | Word selected by the subentry offset |

## Verification
A returning line and a pending insertion can compete for the same idle cycle, since both would update the row store and the pool. The bench presents both in one cycle. It checks that only the response handshake completes and that no insertion is accepted during the whole drain. It then checks that the held insertion completes afterwards and that its line drains correctly later. Random mixes of starts, appends and drains compare every stall length and every response against a bench model of chains, pool and tail cache.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int SB_LINES  = 4;
    localparam int SB_ROWS   = 8;
    localparam int SB_SLOTS  = 2;
    localparam int SB_ID_W   = 4;
    localparam int SB_WORDS  = 4;
    localparam int SB_WORD_W = 8;

    localparam int LINE_W = (SB_LINES > 1) ? $clog2(SB_LINES) : 1;
    localparam int ROW_W  = (SB_ROWS > 1) ? $clog2(SB_ROWS) : 1;
    localparam int PTR_W  = ROW_W + 1;
    localparam int CNT_W  = $clog2(SB_SLOTS + 1);
    localparam int SLOT_W = (SB_SLOTS > 1) ? $clog2(SB_SLOTS) : 1;
    localparam int OFF_W  = (SB_WORDS > 1) ? $clog2(SB_WORDS) : 1;
    localparam int DATA_W = SB_WORDS * SB_WORD_W;

    typedef struct packed {
        logic [SB_ID_W-1:0] id;
        logic [OFF_W-1:0]   off;
    } sub_t;

    typedef struct packed {
        logic [CNT_W-1:0]           cnt;
        logic [PTR_W-1:0]           nxt;
        sub_t [SB_SLOTS-1:0]        sub;
    } row_t;

    typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_DRAIN} fsm_e;
endpackage

// File: rtl/sb_free_queue.sv
module sb_free_queue #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [IDX_W-1:0] push_idx,
    input  logic             pop,
    output logic [IDX_W-1:0] pop_idx,
    output logic             empty
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] slot;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } fq_t;

    function automatic fq_t init_q();
        fq_t v;
        v = '0;
        for (int i = 0; i < DEPTH; i++) v.slot[i] = IDX_W'(i);
        v.cnt = CNT_W'(DEPTH);
        return v;
    endfunction

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    fq_t q, d;

    assign pop_idx = q.slot[q.rd];
    assign empty   = (q.cnt == '0);

    always_comb begin
        d = q;
        if (pop && !empty) begin
            d.rd = step(q.rd);
        end
        if (push) begin
            d.slot[q.wr] = push_idx;
            d.wr         = step(q.wr);
        end
        if (push && !(pop && !empty))      d.cnt = q.cnt + 1'b1;
        else if (!push && pop && !empty)   d.cnt = q.cnt - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= init_q();
        else        q <= d;
    end
endmodule

// File: rtl/sb_word_pick.sv
module sb_word_pick #(
    parameter int WORDS  = 4,
    parameter int WORD_W = 8,
    parameter int OFF_W  = 2
) (
    input  logic [WORDS*WORD_W-1:0] line_data,
    input  logic [OFF_W-1:0]        off,
    output logic [WORD_W-1:0]       word
);
    logic [WORDS-1:0][WORD_W-1:0] words;

    for (genvar k = 0; k < WORDS; k++) begin : g_split
        assign words[k] = line_data[k*WORD_W +: WORD_W];
    end

    assign word = words[off];
endmodule

// File: rtl/sb_row_buffer.sv
module sb_row_buffer
    import sb_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ins_valid,
    output logic                 ins_ready,
    input  logic                 ins_new,
    input  logic [LINE_W-1:0]    ins_line,
    input  logic [SB_ID_W-1:0]   ins_id,
    input  logic [OFF_W-1:0]     ins_off,
    input  logic                 rsp_valid,
    output logic                 rsp_ready,
    input  logic [LINE_W-1:0]    rsp_line,
    input  logic [DATA_W-1:0]    rsp_data,
    output logic                 out_valid,
    output logic [SB_ID_W-1:0]   out_id,
    output logic [SB_WORD_W-1:0] out_word
);
    localparam logic [PTR_W-1:0] NIL      = {1'b1, {ROW_W{1'b0}}};
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(SB_SLOTS);

    typedef struct packed {
        fsm_e                          fsm;
        row_t [SB_ROWS-1:0]            rows;
        logic [SB_LINES-1:0][ROW_W-1:0] head;
        logic                          lrc_vld;
        logic [LINE_W-1:0]             lrc_line;
        logic [ROW_W-1:0]              lrc_row;
        logic [ROW_W-1:0]              cur;
        logic [CNT_W-1:0]              idx;
        logic [LINE_W-1:0]             line;
        logic [DATA_W-1:0]             data;
    } st_t;

    st_t q, d;

    logic             fq_push, fq_pop, fq_empty;
    logic [ROW_W-1:0] fq_pop_idx, fq_push_idx;
    logic [OFF_W-1:0] sel_off;
    row_t             tail_r, cur_r, fresh_r;
    logic             lrc_hit, row_last;

    sb_free_queue #(.DEPTH(SB_ROWS), .IDX_W(ROW_W)) i_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (fq_push),
        .push_idx (fq_push_idx),
        .pop      (fq_pop),
        .pop_idx  (fq_pop_idx),
        .empty    (fq_empty)
    );

    sb_word_pick #(.WORDS(SB_WORDS), .WORD_W(SB_WORD_W), .OFF_W(OFF_W)) i_pick (
        .line_data (q.data),
        .off       (sel_off),
        .word      (out_word)
    );

    always_comb begin
        d           = q;
        ins_ready   = 1'b0;
        rsp_ready   = 1'b0;
        fq_pop      = 1'b0;
        fq_push     = 1'b0;
        fq_push_idx = q.cur;
        out_valid   = 1'b0;
        tail_r      = q.rows[q.lrc_row];
        cur_r       = q.rows[q.cur];
        out_id      = cur_r.sub[q.idx[SLOT_W-1:0]].id;
        sel_off     = cur_r.sub[q.idx[SLOT_W-1:0]].off;
        lrc_hit     = q.lrc_vld && (q.lrc_line == ins_line);
        row_last    = (cur_r.cnt == '0) || (q.idx == cur_r.cnt - 1'b1);
        fresh_r     = '0;
        fresh_r.nxt = NIL;

        unique case (q.fsm)
            ST_IDLE: begin
                if (rsp_valid) begin
                    rsp_ready = 1'b1;
                    d.fsm     = ST_DRAIN;
                    d.cur     = q.head[rsp_line];
                    d.idx     = '0;
                    d.line    = rsp_line;
                    d.data    = rsp_data;
                end else if (ins_valid) begin
                    if (ins_new) begin
                        if (!fq_empty) begin
                            ins_ready            = 1'b1;
                            fq_pop               = 1'b1;
                            fresh_r.cnt          = CNT_W'(1);
                            fresh_r.sub[0]       = '{id: ins_id, off: ins_off};
                            d.rows[fq_pop_idx]   = fresh_r;
                            d.head[ins_line]     = fq_pop_idx;
                            d.lrc_vld            = 1'b1;
                            d.lrc_line           = ins_line;
                            d.lrc_row            = fq_pop_idx;
                        end
                    end else if (lrc_hit) begin
                        if (tail_r.cnt != FULL_CNT) begin
                            ins_ready = 1'b1;
                            d.rows[q.lrc_row].sub[tail_r.cnt[SLOT_W-1:0]] =
                                '{id: ins_id, off: ins_off};
                            d.rows[q.lrc_row].cnt = tail_r.cnt + 1'b1;
                        end else if (!fq_empty) begin
                            fq_pop                 = 1'b1;
                            d.rows[fq_pop_idx]     = fresh_r;
                            d.rows[q.lrc_row].nxt  = {1'b0, fq_pop_idx};
                            d.lrc_row              = fq_pop_idx;
                        end
                    end else begin
                        d.fsm = ST_WALK;
                        d.cur = q.head[ins_line];
                    end
                end
            end
            ST_WALK: begin
                if (cur_r.nxt[PTR_W-1]) begin
                    d.fsm      = ST_IDLE;
                    d.lrc_vld  = 1'b1;
                    d.lrc_line = ins_line;
                    d.lrc_row  = q.cur;
                end else begin
                    d.cur = cur_r.nxt[ROW_W-1:0];
                end
            end
            ST_DRAIN: begin
                out_valid = (q.idx < cur_r.cnt);
                if (row_last) begin
                    fq_push = 1'b1;
                    d.idx   = '0;
                    if (cur_r.nxt[PTR_W-1]) begin
                        d.fsm = ST_IDLE;
                        if (q.lrc_line == q.line) d.lrc_vld = 1'b0;
                    end else begin
                        d.cur = cur_r.nxt[ROW_W-1:0];
                    end
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            default: d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.fsm <= ST_IDLE;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/sb_row_buffer_chk.sv
module sb_row_buffer_chk
    import sb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               ins_valid,
    input logic               ins_ready,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic               out_valid,
    input logic [SB_ID_W-1:0] out_id
);
    p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_ready |-> ins_valid);

    p_drain_blocks_ins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!ins_ready && !rsp_ready));

    p_rsp_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && ins_valid) |-> !ins_ready);

    p_drain_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready) |=> !rsp_ready);

    p_out_known_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_id));
endmodule

bind sb_row_buffer sb_row_buffer_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ins_valid (ins_valid),
    .ins_ready (ins_ready),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .out_valid (out_valid),
    .out_id    (out_id)
);

// File: tb/test_sb_row_buffer.sv
module test_sb_row_buffer;
    import sb_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ins_valid = 1'b0, ins_new = 1'b0;
    logic [LINE_W-1:0] ins_line = '0;
    logic [SB_ID_W-1:0] ins_id = '0;
    logic [OFF_W-1:0] ins_off = '0;
    logic rsp_valid = 1'b0;
    logic [LINE_W-1:0] rsp_line = '0;
    logic [DATA_W-1:0] rsp_data = '0;
    logic ins_ready, rsp_ready, out_valid;
    logic [SB_ID_W-1:0] out_id;
    logic [SB_WORD_W-1:0] out_word;

    int n_tests = 0, n_fail = 0;

    // bench model
    int n_ent [SB_LINES];
    int rows_of [SB_LINES];
    int e_id [SB_LINES][16];
    int e_off [SB_LINES][16];
    int free_rows = SB_ROWS;
    bit m_lrc_vld = 0;
    int m_lrc_line = 0;

    always #5 clk = ~clk;

    sb_row_buffer i_sb_row_buffer (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_new(ins_new),
        .ins_line(ins_line), .ins_id(ins_id), .ins_off(ins_off),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_line(rsp_line),
        .rsp_data(rsp_data), .out_valid(out_valid), .out_id(out_id), .out_word(out_word)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_wait(input int ln);
        int w;
        bit full;
        full = (n_ent[ln] % SB_SLOTS) == 0;
        w = (m_lrc_vld && m_lrc_line == ln) ? 0 : rows_of[ln] + 1;
        if (full) w++;
        return w;
    endfunction

    function automatic int pick(input logic [DATA_W-1:0] dat, input int off);
        return int'(dat[off*SB_WORD_W +: SB_WORD_W]);
    endfunction

    task automatic model_add(input int ln, input bit nw, input int id, input int off);
        if (nw) begin
            n_ent[ln] = 0; rows_of[ln] = 1; free_rows--;
        end else if ((n_ent[ln] % SB_SLOTS) == 0) begin
            rows_of[ln]++; free_rows--;
        end
        e_id[ln][n_ent[ln]] = id;
        e_off[ln][n_ent[ln]] = off;
        n_ent[ln]++;
        m_lrc_vld = 1; m_lrc_line = ln;
    endtask

    task automatic do_ins(input int ln, input bit nw, input int id, input int off, input string tag);
        int w, ew;
        ew = nw ? 0 : exp_wait(ln);
        @(negedge clk);
        ins_valid = 1; ins_new = nw; ins_line = LINE_W'(ln);
        ins_id = SB_ID_W'(id); ins_off = OFF_W'(off);
        w = 0;
        #1;
        while (!ins_ready && w < 60) begin
            @(negedge clk); #1; w++;
        end
        chk(w == ew, tag, w, ew);
        @(posedge clk); #1;
        ins_valid = 0;
        model_add(ln, nw, id, off);
    endtask

    task automatic collect(input int ln, input logic [DATA_W-1:0] dat, input string tag);
        int got;
        got = 0;
        for (int c = 0; c < n_ent[ln] + rows_of[ln] + 4; c++) begin
            @(negedge clk); #1;
            if (out_valid) begin
                if (got < n_ent[ln]) begin
                    chk(int'(out_id) == e_id[ln][got], {tag, " id"}, int'(out_id), e_id[ln][got]);
                    chk(int'(out_word) == pick(dat, e_off[ln][got]), {tag, " word"},
                        int'(out_word), pick(dat, e_off[ln][got]));
                end
                got++;
            end
        end
        chk(got == n_ent[ln], {tag, " count"}, got, n_ent[ln]);
        free_rows += rows_of[ln];
        n_ent[ln] = 0; rows_of[ln] = 0;
        if (m_lrc_vld && m_lrc_line == ln) m_lrc_vld = 0;
    endtask

    task automatic do_rsp(input int ln, input string tag);
        logic [DATA_W-1:0] dat;
        dat = DATA_W'($urandom);
        @(negedge clk);
        rsp_valid = 1; rsp_line = LINE_W'(ln); rsp_data = dat;
        #1;
        chk(rsp_ready == 1'b1, "R6 rsp accepted when idle", int'(rsp_ready), 1);
        @(posedge clk); #1;
        rsp_valid = 0;
        collect(ln, dat, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < SB_LINES; i++) begin n_ent[i] = 0; rows_of[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R1 no output after reset", int'(out_valid), 0);
        chk(ins_ready == 1'b0, "R2 no ready without valid", int'(ins_ready), 0);

        // R2/R3/R4: start, back-to-back append, full tail
        do_ins(0, 1, 1, 2, "R2 new line accepted at once");
        do_ins(0, 0, 2, 0, "R3 append with space no stall");
        do_ins(0, 0, 3, 3, "R4 full tail stalls one cycle");
        do_ins(0, 0, 4, 1, "R3 append after link");
        // R5: switch line, then come back with cache miss
        do_ins(1, 1, 5, 1, "R2 second line start");
        do_ins(0, 0, 6, 2, "R5 tail cache miss walk plus link");
        do_ins(1, 0, 7, 0, "R5 tail cache miss one row");
        do_rsp(0, "R6 drain line 0");
        do_rsp(1, "R6 drain line 1");

        // R1/R8/R7: exhaust pool
        for (int l = 0; l < SB_LINES; l++) do_ins(l, 1, l, l, "R1 fill start");
        for (int k = 0; k < 7; k++) do_ins(0, 0, 8 + k, k % SB_WORDS, "R1 fill line 0");
        do_ins(1, 0, 9, 3, "R1 fill line 1");
        do_ins(1, 0, 10, 2, "R1 fill line 1 last row");
        do_ins(1, 0, 11, 1, "R3 fill slot of last row");
        chk(free_rows == 0, "R1 model pool empty", free_rows, 0);
        @(negedge clk);
        ins_valid = 1; ins_new = 0; ins_line = 1; ins_id = 12; ins_off = 0;
        for (int c = 0; c < 6; c++) begin
            #1 chk(ins_ready == 1'b0, "R8 blocked with empty pool", int'(ins_ready), 0);
            @(negedge clk);
        end
        ins_valid = 0;
        do_rsp(0, "R7 drain frees rows");
        do_ins(1, 0, 12, 0, "R7 freed row reused");
        do_ins(0, 1, 13, 3, "R7 line index restart");

        // R9: response and request in the same idle cycle
        begin
            logic [DATA_W-1:0] dat;
            int w;
            dat = DATA_W'($urandom);
            @(negedge clk);
            rsp_valid = 1; rsp_line = 1; rsp_data = dat;
            ins_valid = 1; ins_new = 0; ins_line = 2; ins_id = 14; ins_off = 2;
            #1;
            chk(rsp_ready == 1'b1, "R9 response taken first", int'(rsp_ready), 1);
            chk(ins_ready == 1'b0, "R9 request waits", int'(ins_ready), 0);
            @(posedge clk); #1;
            rsp_valid = 0;
            w = 0;
            for (int c = 0; c < n_ent[1]; c++) begin
                @(negedge clk); #1;
                chk(out_valid && !ins_ready, "R9 no insert during drain", int'(ins_ready), 0);
            end
            free_rows += rows_of[1]; n_ent[1] = 0; rows_of[1] = 0;
            if (m_lrc_line == 1) m_lrc_vld = 0;
            while (!ins_ready && w < 60) begin @(negedge clk); #1; w++; end
            chk(ins_ready == 1'b1, "R9 held request completes", int'(ins_ready), 1);
            @(posedge clk); #1;
            ins_valid = 0;
            model_add(2, 0, 14, 2);
        end
        for (int l = 0; l < SB_LINES; l++) if (n_ent[l] > 0) do_rsp(l, "R6 flush");

        // random mix
        for (int it = 0; it < 300; it++) begin
            int ln, op;
            ln = int'($urandom % SB_LINES);
            op = int'($urandom % 4);
            if (n_ent[ln] == 0) begin
                if (free_rows > 0) do_ins(ln, 1, int'($urandom % 16), int'($urandom % SB_WORDS), "R2 random start");
            end else if (op == 0) begin
                do_rsp(ln, "R6 random drain");
            end else if (n_ent[ln] < 16 && ((n_ent[ln] % SB_SLOTS) != 0 || free_rows > 0)) begin
                do_ins(ln, 0, int'($urandom % 16), int'($urandom % SB_WORDS), "R5 random append");
            end
        end
        for (int l = 0; l < SB_LINES; l++) if (n_ent[l] > 0) do_rsp(l, "R7 final flush");
        chk(free_rows == SB_ROWS, "R7 model pool restored", free_rows, SB_ROWS);
        for (int l = 0; l < SB_LINES; l++) do_ins(l, 1, l, 0, "R7 all rows available");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule